// File: doc/BRIEF.md
# Fixed-Point Vector Multiply-Accumulate Lanes

This block performs a multiply or a multiply-accumulate across a set of parallel lanes, four by default. Each lane multiplies a 16-bit signed element of the first operand vector by a 16-bit signed element of the second. The second element is either the lane's own element, or one element chosen by index and sent to every lane.

A multiply replaces the lane's 32-bit accumulator with the product. A multiply-accumulate adds the product to the accumulator. A signed shift amount scales the result.

In the normal (single-precision) mode, the shift is applied on the way from the accumulator to the 16-bit destination element. A multiply with a shift of exactly -15 rounds to nearest. In double-precision mode, the shift is applied to the product before it reaches the accumulator. The destination element is then the 15 fractional bits of the new accumulator, with bit 15 clear. This mode is used to build the low half of a two-word fixed-point result.

A start strobe launches one operation. Destination and accumulator outputs are registered and become valid on the next cycle. They hold their values until the next strobe.

Top module: `vmac_lanes`

## Requirements
- R1: While `rst` is high at a clock edge, every accumulator, every destination element and `valid` become zero on that edge.
- R2: With `scalar_en` low, lane i uses T element i. With `scalar_en` high, every lane uses T element `scalar_idx`. Lane i occupies bits [16*i+15:16*i] of `vs_in`, `vt_in` and `vd_out`, and bits [32*i+31:32*i] of `acc_out`.
- R3: `shift` is a 6-bit two's-complement value. A positive value shifts left by that many bits. A negative value shifts arithmetically right by its magnitude, so -32 fills the value with its sign bit.
- R4: A single-precision multiply (`op_mac`=0, `dbl`=0) loads the accumulator with the product, plus 16384 only when `shift` is exactly -15. The destination element is the low 16 bits of the shifted accumulator.
- R5: A double-precision multiply (`op_mac`=0, `dbl`=1) loads the accumulator with the shifted product, with no rounding constant. The destination element is accumulator bits [14:0] with bit 15 zero.
- R6: A single-precision multiply-accumulate (`op_mac`=1, `dbl`=0) adds the unshifted product to the accumulator, never with a rounding constant, even at shift -15. The destination element is the low 16 bits of the shifted new accumulator.
- R7: A double-precision multiply-accumulate (`op_mac`=1, `dbl`=1) adds the shifted product to the accumulator. The destination element is new accumulator bits [14:0] with bit 15 zero.
- R8: Accumulator arithmetic is modulo 2^32 and wraps on overflow.
- R9: `valid` is high exactly in the cycle after a cycle with `start` high. Accumulators and destination elements change only on a start edge, and the new values are visible in that next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation this cycle |
| op_mac | input | 1 | 0 = multiply, 1 = multiply-accumulate |
| dbl | input | 1 | Double-precision mode |
| shift | input | 6 | Signed post-scale amount |
| scalar_en | input | 1 | Broadcast one T element to all lanes |
| scalar_idx | input | 2 | Index of the broadcast T element |
| vs_in | input | 64 | S operand vector, packed lanes |
| vt_in | input | 64 | T operand vector, packed lanes |
| vd_out | output | 64 | Destination vector, packed lanes |
| acc_out | output | 128 | Accumulators, packed lanes |
| valid | output | 1 | Outputs hold the result of the previous start |

## Verification
The hardest states to reach are the ones that exist only in narrow cases. Round-to-nearest applies only to a multiply at a shift of exactly -15. Wraparound needs the accumulator to climb past 2^31. Random 16-bit operands almost never sum a running total that high. So directed sequences chain multiply-accumulates of -32768 by -32768 until the sign flips. The directed cases also put multiply and multiply-accumulate at shift -15 side by side, and cover the shift extremes -32 and +31. Random vectors then mix modes, broadcast indices and shift values over a model that carries its accumulators forward.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAC = 1'b1
  } vmac_op_e;

  typedef struct packed {
    logic     start;
    vmac_op_e op;
    logic     dbl;
  } vmac_ctl_t;
endpackage

// File: rtl/vmac_shifter.sv
module vmac_shifter #(
  parameter int W   = 32,
  parameter int SHW = 6
) (
  input  logic signed [W-1:0]   x,
  input  logic signed [SHW-1:0] amt,
  output logic signed [W-1:0]   y
);
  logic [SHW-1:0] mag;

  always_comb begin
    mag = SHW'(-amt);
    if (amt[SHW-1]) y = x >>> mag;
    else            y = x <<  amt[SHW-2:0];
  end
endmodule

// File: rtl/vmac_operand_sel.sv
module vmac_operand_sel #(
  parameter int LANES = 4,
  parameter int DW    = 16,
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*DW-1:0] vs_in,
  input  logic [LANES*DW-1:0] vt_in,
  input  logic                scalar_en,
  input  logic [IW-1:0]       scalar_idx,
  output logic [DW-1:0]       s_lane [LANES],
  output logic [DW-1:0]       t_lane [LANES]
);
  logic [DW-1:0] t_all [LANES];
  logic [DW-1:0] t_bcast;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign s_lane[i] = vs_in[i*DW +: DW];
    assign t_all[i]  = vt_in[i*DW +: DW];
  end

  assign t_bcast = t_all[scalar_idx];

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    assign t_lane[i] = scalar_en ? t_bcast : t_all[i];
  end
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
  import vmac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SHW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  vmac_ctl_t       ctl,
  input  logic [SHW-1:0]  shift,
  input  logic [DW-1:0]   s_elem,
  input  logic [DW-1:0]   t_elem,
  output logic [DW-1:0]   vd_q,
  output logic [AW-1:0]   acc_q
);
  localparam int FRAC = DW - 1;
  localparam logic signed [SHW-1:0] RND_SHIFT = SHW'(-FRAC);
  localparam logic signed [AW-1:0]  RND_CONST = AW'(1) << (FRAC - 1);

  logic signed [AW-1:0] prod;
  logic signed [AW-1:0] prod_sh;
  logic signed [AW-1:0] acc_base;
  logic signed [AW-1:0] rnd;
  logic signed [AW-1:0] acc_nxt;
  logic signed [AW-1:0] acc_sh;
  logic        [DW-1:0] vd_nxt;

  assign prod = AW'($signed(s_elem)) * AW'($signed(t_elem));

  vmac_shifter #(.W(AW), .SHW(SHW)) u_prod_sh (
    .x(prod), .amt($signed(shift)), .y(prod_sh)
  );

  always_comb begin
    acc_base = (ctl.op == OP_MAC) ? $signed(acc_q) : '0;
    rnd      = (ctl.op == OP_MUL && !ctl.dbl && $signed(shift) == RND_SHIFT)
               ? RND_CONST : '0;
    acc_nxt  = ctl.dbl ? (acc_base + prod_sh) : (acc_base + prod + rnd);
  end

  vmac_shifter #(.W(AW), .SHW(SHW)) u_acc_sh (
    .x(acc_nxt), .amt($signed(shift)), .y(acc_sh)
  );

  assign vd_nxt = ctl.dbl ? {1'b0, acc_nxt[FRAC-1:0]} : acc_sh[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vd_q  <= '0;
    end else if (ctl.start) begin
      acc_q <= acc_nxt;
      vd_q  <= vd_nxt;
    end
  end
endmodule

// File: rtl/vmac_lanes.sv
module vmac_lanes
  import vmac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int SHW   = 6,
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op_mac,
  input  logic                dbl,
  input  logic [SHW-1:0]      shift,
  input  logic                scalar_en,
  input  logic [IW-1:0]       scalar_idx,
  input  logic [LANES*DW-1:0] vs_in,
  input  logic [LANES*DW-1:0] vt_in,
  output logic [LANES*DW-1:0] vd_out,
  output logic [LANES*AW-1:0] acc_out,
  output logic                valid
);
  logic [DW-1:0] s_lane [LANES];
  logic [DW-1:0] t_lane [LANES];
  vmac_ctl_t     ctl;

  assign ctl.start = start;
  assign ctl.op    = vmac_op_e'(op_mac);
  assign ctl.dbl   = dbl;

  vmac_operand_sel #(.LANES(LANES), .DW(DW)) u_sel (
    .vs_in(vs_in), .vt_in(vt_in),
    .scalar_en(scalar_en), .scalar_idx(scalar_idx),
    .s_lane(s_lane), .t_lane(t_lane)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vmac_lane #(.DW(DW), .AW(AW), .SHW(SHW)) u_lane (
      .clk(clk), .rst(rst), .ctl(ctl), .shift(shift),
      .s_elem(s_lane[i]), .t_elem(t_lane[i]),
      .vd_q(vd_out[i*DW +: DW]), .acc_q(acc_out[i*AW +: AW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= start;
  end
endmodule

// File: rtl/vmac_lanes_chk.sv
module vmac_lanes_chk #(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int AW    = 32,
  parameter int SHW   = 6,
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                op_mac,
  input logic                dbl,
  input logic [SHW-1:0]      shift,
  input logic                scalar_en,
  input logic [IW-1:0]       scalar_idx,
  input logic [LANES*DW-1:0] vs_in,
  input logic [LANES*DW-1:0] vt_in,
  input logic [LANES*DW-1:0] vd_out,
  input logic [LANES*AW-1:0] acc_out,
  input logic                valid
);
  logic [LANES-1:0] vd_msb;
  for (genvar i = 0; i < LANES; i++) begin : g_msb
    assign vd_msb[i] = vd_out[i*DW + DW - 1];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && vd_out == '0 && !valid));

  a_r9_valid_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(acc_out) && $stable(vd_out) && !valid));

  a_r5_r7_dbl_top_clear: assert property (@(posedge clk) disable iff (rst)
    (start && dbl) |=> (vd_msb == '0));

  a_r6_zero_t_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (start && op_mac && !dbl && !scalar_en && vt_in == '0) |=> $stable(acc_out));
endmodule

bind vmac_lanes vmac_lanes_chk #(.LANES(LANES), .DW(DW), .AW(AW), .SHW(SHW)) u_chk (.*);

// File: tb/vmac_lanes_tb.sv
`timescale 1ns/1ps
module vmac_lanes_tb;
  localparam int LANES = 4;
  localparam int DW = 16;
  localparam int AW = 32;
  localparam int SHW = 6;

  logic clk = 0;
  logic rst = 1;
  logic start = 0, op_mac = 0, dbl = 0, scalar_en = 0;
  logic [SHW-1:0] shift = '0;
  logic [1:0] scalar_idx = '0;
  logic [LANES*DW-1:0] vs_in = '0, vt_in = '0;
  logic [LANES*DW-1:0] vd_out;
  logic [LANES*AW-1:0] acc_out;
  logic valid;

  int n_chk = 0;
  int n_bad = 0;
  logic signed [AW-1:0] acc_m [LANES];
  logic [DW-1:0] vd_m [LANES];

  always #2 clk = ~clk;

  vmac_lanes u_dut (
    .clk(clk), .rst(rst), .start(start), .op_mac(op_mac), .dbl(dbl),
    .shift(shift), .scalar_en(scalar_en), .scalar_idx(scalar_idx),
    .vs_in(vs_in), .vt_in(vt_in), .vd_out(vd_out), .acc_out(acc_out),
    .valid(valid)
  );

  function automatic logic signed [31:0] scale(logic signed [31:0] x, int sh);
    if (sh >= 0) return x <<< sh;
    if (sh <= -32) return {32{x[31]}};
    return x >>> (-sh);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic compare(string tag);
    logic [LANES*DW-1:0] evd;
    logic [LANES*AW-1:0] eacc;
    for (int i = 0; i < LANES; i++) begin
      evd[i*DW +: DW]  = vd_m[i];
      eacc[i*AW +: AW] = acc_m[i];
    end
    n_chk++;
    if (vd_out !== evd || acc_out !== eacc || valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: vd=%h acc=%h valid=%b expected vd=%h acc=%h valid=1",
               tag, vd_out, acc_out, valid, evd, eacc);
    end
  endtask

  // drive one operation, update the model, check outputs the cycle after
  task automatic apply(input logic mac, input logic dp, input int sh,
                       input logic sc, input int idx,
                       input logic [63:0] vs, input logic [63:0] vt,
                       input string tag);
    @(negedge clk);
    start = 1; op_mac = mac; dbl = dp; shift = SHW'(sh);
    scalar_en = sc; scalar_idx = 2'(idx); vs_in = vs; vt_in = vt;
    for (int i = 0; i < LANES; i++) begin
      logic signed [31:0] p, base, nxt;
      logic signed [15:0] se, te;
      se = vs[i*DW +: DW];
      te = sc ? vt[idx*DW +: DW] : vt[i*DW +: DW];
      p = 32'(se) * 32'(te);
      base = mac ? acc_m[i] : 32'sd0;
      if (dp) begin
        nxt = base + scale(p, sh);
        vd_m[i] = {1'b0, nxt[14:0]};
      end else begin
        nxt = base + p + ((!mac && sh == -15) ? 32'sd16384 : 32'sd0);
        vd_m[i] = scale(nxt, sh) & 32'hFFFF;
      end
      acc_m[i] = nxt;
    end
    @(negedge clk);
    start = 0;
    compare(tag);
  endtask

  function automatic logic [63:0] rep(logic [15:0] v);
    return {v, v, v, v};
  endfunction

  initial begin
    for (int i = 0; i < LANES; i++) begin acc_m[i] = 0; vd_m[i] = 0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (acc_out !== '0 || vd_out !== '0 || valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: vd=%h acc=%h valid=%b expected all zero",
               vd_out, acc_out, valid);
    end
    rst = 0;

    // R4 rounding at -15 only, R3 shifts
    apply(0, 0, -15, 0, 0, rep(16'h4000), {16'h0001, 16'h7FFF, 16'h8000, 16'h3FFF}, "R4 mul round -15");
    apply(0, 0, -14, 0, 0, rep(16'h4000), {16'h0001, 16'h7FFF, 16'h8000, 16'h3FFF}, "R4 mul -14 no round");
    apply(0, 0, 31, 0, 0, {16'h0001, 16'hFFFF, 16'h0003, 16'h8000}, rep(16'h0001), "R3 shift +31");
    apply(0, 0, -32, 0, 0, {16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF}, rep(16'h7FFF), "R3 shift -32");
    apply(0, 1, -15, 0, 0, {16'h1234, 16'h8000, 16'h7FFF, 16'hABCD}, {16'h5678, 16'h8000, 16'h7FFF, 16'h0003}, "R5 dbl mul");
    apply(0, 1, 4, 0, 0, rep(16'h0FFF), rep(16'hF00F), "R5 dbl mul shl");
    // R6 no rounding on mac at -15
    apply(0, 0, 0, 0, 0, rep(16'h0000), rep(16'h0000), "R4 mul clear");
    apply(1, 0, -15, 0, 0, rep(16'h4000), rep(16'h0003), "R6 mac -15 no round");
    apply(1, 1, -3, 0, 0, rep(16'h1111), rep(16'hEEEE), "R7 dbl mac");
    // R8 wrap: 3 x 2^30 past 2^31
    apply(0, 0, 0, 0, 0, rep(16'h8000), rep(16'h8000), "R8 load 2^30");
    apply(1, 0, 0, 0, 0, rep(16'h8000), rep(16'h8000), "R8 mac to 2^31 wrap");
    apply(1, 0, -16, 0, 0, rep(16'h8000), rep(16'h8000), "R8 mac past wrap");
    // R2 broadcast
    for (int k = 0; k < 4; k++)
      apply(0, 0, 0, 1, k, {16'h0004, 16'h0003, 16'h0002, 16'h0001},
            {16'h0040, 16'h0030, 16'h0020, 16'h0010}, "R2 scalar broadcast");

    // R9 hold: idle cycle, outputs unchanged and valid low
    @(negedge clk);
    vs_in = '1; vt_in = '1; op_mac = 1;
    @(negedge clk);
    n_chk++;
    begin
      logic [LANES*AW-1:0] eacc;
      for (int i = 0; i < LANES; i++) eacc[i*AW +: AW] = acc_m[i];
      if (valid !== 1'b0 || acc_out !== eacc) begin
        n_bad++;
        $display("FAIL R9 idle hold: acc=%h valid=%b expected acc=%h valid=0",
                 acc_out, valid, eacc);
      end
    end

    // random mix
    void'($urandom(32'h5EED1));
    for (int n = 0; n < 400; n++) begin
      logic mac, dp, sc;
      int sh, idx;
      mac = 1'($urandom);
      dp  = 1'($urandom);
      sc  = ($urandom % 4) == 0;
      idx = $urandom % 4;
      sh  = ($urandom % 5 == 0) ? -15 : (int'($urandom % 64) - 32);
      apply(mac, dp, sh, sc, idx, {$urandom, $urandom}, {$urandom, $urandom},
            mac ? (dp ? "R7 rand" : "R6 rand") : (dp ? "R5 rand" : "R4 rand"));
    end

    // R1 reset mid-run clears state
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    n_chk++;
    if (acc_out !== '0 || vd_out !== '0 || valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 re-reset: vd=%h acc=%h valid=%b expected all zero",
               vd_out, acc_out, valid);
    end
    summary();
  end
endmodule